// File: doc/BRIEF.md
# Keypad Digit Entry With Mode Toggle

This block sits behind the debounce filters of a combination lock. Four push-buttons each own one decimal digit. Every fresh press of a button advances that digit by one, counting 0 to 9 and then back to 0. A fifth button flips a sticky mode level. The level chooses between typing a code (level 0) and rewriting the stored code (level 1). Comparison against the stored code and all display work happen downstream.

An external inactivity timer can drop the active-low clear input for one clock. That returns every digit to 0, which the rest of the lock reads as the idle combination. The mode level keeps its value through the clear. All outputs come straight from flops.

Top module: `keypad_entry`

## Requirements
- R1: While `rst` is high at a rising clock edge, every digit becomes 0 and `edit_mode_o` becomes 0 (code entry) after that edge.
- R2: A press is the first clock edge at which `key_i[k]` is sampled 1 after being sampled 0. At that edge, digit k (bits `k*4+3:k*4` of `digits_o`) increases by one.
- R3: A key held high across many edges counts only once. Digit k stays unchanged at every edge where `key_i[k]` was already high at the previous edge.
- R4: A press on a digit holding 9 sets it to 0, so no digit ever holds a value above 9.
- R5: Presses on several keys at the same edge are all applied at that edge, each to its own digit.
- R6: When `clr_n_i` is sampled 0, all digits are 0 after that edge, even if a key press arrives at the same edge. That press is lost, and a key held high through the clear is not counted when the clear ends.
- R7: The clear leaves `edit_mode_o` unchanged.
- R8: Each press of `mode_key_i` inverts `edit_mode_o` once. The first press after reset sets it to 1 (code change), and the next press sets it back to 0. Holding the key gives one toggle only.
- R9: A key already high while reset is applied is not counted when reset ends. It must be released and pressed again.
- R10: Digit keys never change `edit_mode_o`, and the mode key never changes any digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_i | input | NUM_KEYS | Debounced digit buttons, 1 = pressed |
| mode_key_i | input | 1 | Debounced mode button, 1 = pressed |
| clr_n_i | input | 1 | Inactivity clear, active low, one cycle |
| digits_o | output | NUM_KEYS*DIGIT_W | Digit k in bits k*DIGIT_W +: DIGIT_W |
| edit_mode_o | output | 1 | 0 = code entry, 1 = code change |

## Verification
The bench builds the block with its defaults: four keys, 4-bit digits and a top count of 9. With these values a full wrap of one digit takes only ten presses, so every step of the count can be checked directly. The directed cases place a key press on the same edge as a clear and hold keys across both reset and the clear. They also hold the mode key for several cycles. This tests the single-count rule at each of the boundaries where a previous-value flop could be loaded wrongly.

// File: rtl/keypad_entry_pkg.sv
package keypad_entry_pkg;

  typedef enum logic {
    MODE_ENTRY  = 1'b0,
    MODE_CHANGE = 1'b1
  } entry_mode_e;

  localparam int unsigned DEF_NUM_KEYS  = 4;
  localparam int unsigned DEF_DIGIT_W   = 4;
  localparam int unsigned DEF_DIGIT_MAX = 9;

endpackage

// File: rtl/keypad_edge_detect.sv
module keypad_edge_detect #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  // Reset loads ones so a button already down at reset release is not a press.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/keypad_digit_cell.sv
module keypad_digit_cell #(
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned DIGIT_MAX = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n_i,
  input  logic               step_i,
  output logic [DIGIT_W-1:0] digit_o
);

  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(DIGIT_MAX);

  logic [DIGIT_W-1:0] digit_q;

  always_ff @(posedge clk) begin
    if (rst)               digit_q <= '0;
    else if (!clr_n_i)     digit_q <= '0;
    else if (step_i) begin
      if (digit_q >= TOP)  digit_q <= '0;
      else                 digit_q <= digit_q + 1'b1;
    end
  end

  assign digit_o = digit_q;

endmodule

// File: rtl/keypad_mode_toggle.sv
module keypad_mode_toggle
  import keypad_entry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flip_i,
  output logic mode_o
);

  entry_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= MODE_ENTRY;
    else if (flip_i) mode_q <= (mode_q == MODE_ENTRY) ? MODE_CHANGE : MODE_ENTRY;
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/keypad_entry.sv
module keypad_entry
  import keypad_entry_pkg::*;
#(
  parameter int unsigned NUM_KEYS  = DEF_NUM_KEYS,
  parameter int unsigned DIGIT_W   = DEF_DIGIT_W,
  parameter int unsigned DIGIT_MAX = DEF_DIGIT_MAX
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_KEYS-1:0]         key_i,
  input  logic                        mode_key_i,
  input  logic                        clr_n_i,
  output logic [NUM_KEYS*DIGIT_W-1:0] digits_o,
  output logic                        edit_mode_o
);

  localparam int unsigned BUTTONS = NUM_KEYS + 1;

  logic [BUTTONS-1:0] rise;

  keypad_edge_detect #(.WIDTH(BUTTONS)) u_edges (
    .clk     (clk),
    .rst     (rst),
    .level_i ({mode_key_i, key_i}),
    .rise_o  (rise)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_digit
    keypad_digit_cell #(
      .DIGIT_W   (DIGIT_W),
      .DIGIT_MAX (DIGIT_MAX)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .clr_n_i (clr_n_i),
      .step_i  (rise[k]),
      .digit_o (digits_o[k*DIGIT_W +: DIGIT_W])
    );
  end

  keypad_mode_toggle u_mode (
    .clk    (clk),
    .rst    (rst),
    .flip_i (rise[NUM_KEYS]),
    .mode_o (edit_mode_o)
  );

endmodule

// File: rtl/keypad_entry_chk.sv
module keypad_entry_chk #(
  parameter int unsigned NUM_KEYS  = 4,
  parameter int unsigned DIGIT_W   = 4,
  parameter int unsigned DIGIT_MAX = 9
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_KEYS-1:0]         key_i,
  input logic                        mode_key_i,
  input logic                        clr_n_i,
  input logic [NUM_KEYS*DIGIT_W-1:0] digits_o,
  input logic                        edit_mode_o
);

  logic [NUM_KEYS:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '1;
    else     seen_q <= {mode_key_i, key_i};
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (digits_o == '0 && edit_mode_o == 1'b0));

  // R6
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n_i |=> digits_o == '0);

  // R7
  mode_steady_chk: assert property (@(posedge clk) disable iff (rst)
    !(mode_key_i && !seen_q[NUM_KEYS]) |=> $stable(edit_mode_o));

  // R8
  mode_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_key_i && !seen_q[NUM_KEYS]) |=> edit_mode_o != $past(edit_mode_o));

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_chk
    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      digits_o[k*DIGIT_W +: DIGIT_W] <= DIGIT_W'(DIGIT_MAX));

    // R3
    held_once_chk: assert property (@(posedge clk) disable iff (rst)
      (key_i[k] && seen_q[k] && clr_n_i) |=> $stable(digits_o[k*DIGIT_W +: DIGIT_W]));
  end

endmodule

bind keypad_entry keypad_entry_chk #(
  .NUM_KEYS  (NUM_KEYS),
  .DIGIT_W   (DIGIT_W),
  .DIGIT_MAX (DIGIT_MAX)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .key_i       (key_i),
  .mode_key_i  (mode_key_i),
  .clr_n_i     (clr_n_i),
  .digits_o    (digits_o),
  .edit_mode_o (edit_mode_o)
);

// File: tb/keypad_entry_test.sv
module keypad_entry_test;

  localparam int NK = 4;
  localparam int DW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NK-1:0]     key_i = '0;
  logic              mode_key_i = 1'b0;
  logic              clr_n_i = 1'b1;
  logic [NK*DW-1:0]  digits_o;
  logic              edit_mode_o;

  int checks = 0;
  int fails  = 0;
  int exp_d [NK];
  logic exp_mode = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keypad_entry uut (
    .clk         (clk),
    .rst         (rst),
    .key_i       (key_i),
    .mode_key_i  (mode_key_i),
    .clr_n_i     (clr_n_i),
    .digits_o    (digits_o),
    .edit_mode_o (edit_mode_o)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NK; k++) begin
      checks++;
      if (int'(digits_o[k*DW +: DW]) != exp_d[k]) begin
        fails++;
        $display("FAIL %s digit%0d actual=%0d expected=%0d", tag, k,
                 digits_o[k*DW +: DW], exp_d[k]);
      end
    end
    checks++;
    if (edit_mode_o !== exp_mode) begin
      fails++;
      $display("FAIL %s mode actual=%0b expected=%0b", tag, edit_mode_o, exp_mode);
    end
  endtask

  function automatic int bump(input int v);
    return (v == 9) ? 0 : v + 1;
  endfunction

  task automatic press(input logic [NK-1:0] m);
    key_i = m; step();
    for (int k = 0; k < NK; k++) if (m[k]) exp_d[k] = bump(exp_d[k]);
    key_i = '0; step();
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1; key_i = '0; mode_key_i = 1'b0; step(3);
    rst = 1'b0; step();
    for (int k = 0; k < NK; k++) exp_d[k] = 0;
    exp_mode = 1'b0;
    check_all("R1");
  endtask

  // R2, R10: single presses step one digit, mode untouched
  task automatic t_single();
    press(4'b0001); press(4'b0001); press(4'b0001);
    press(4'b0100);
    check_all("R2_R10");
  endtask

  // R3: holding a key counts once
  task automatic t_hold();
    key_i = 4'b0010; step();
    exp_d[1] = bump(exp_d[1]);
    step(5);
    check_all("R3");
    key_i = '0; step();
    check_all("R3");
  endtask

  // R4: 9 wraps to 0
  task automatic t_wrap();
    while (exp_d[3] != 9) press(4'b1000);
    check_all("R4");
    press(4'b1000);
    check_all("R4");
  endtask

  // R5: simultaneous presses
  task automatic t_simul();
    press(4'b1111);
    check_all("R5");
    press(4'b1010);
    check_all("R5");
  endtask

  // R8, R10: mode toggle, held once, digits untouched
  task automatic t_mode();
    mode_key_i = 1'b1; step();
    exp_mode = ~exp_mode;
    step(4);
    check_all("R8_R10");
    mode_key_i = 1'b0; step();
    mode_key_i = 1'b1; step();
    exp_mode = ~exp_mode;
    mode_key_i = 1'b0; step();
    check_all("R8");
    mode_key_i = 1'b1; step(); mode_key_i = 1'b0; step();
    exp_mode = ~exp_mode;
    check_all("R8");
  endtask

  // R6, R7: clear wins over a same-edge press, mode kept, held key lost
  task automatic t_clear();
    press(4'b0111);
    clr_n_i = 1'b0; key_i = 4'b0001; step();
    clr_n_i = 1'b1;
    for (int k = 0; k < NK; k++) exp_d[k] = 0;
    check_all("R6_R7");
    step(3);
    check_all("R6");
    key_i = '0; step();
    check_all("R6");
    press(4'b0001);
    check_all("R6");
  endtask

  // R9: key held through reset is not counted
  task automatic t_reset_hold();
    rst = 1'b1; key_i = 4'b0100; step(2);
    rst = 1'b0;
    for (int k = 0; k < NK; k++) exp_d[k] = 0;
    exp_mode = 1'b0;
    step(3);
    check_all("R9");
    key_i = '0; step();
    press(4'b0100);
    check_all("R9");
  endtask

  initial begin
    for (int k = 0; k < NK; k++) exp_d[k] = 0;
    step();
    t_reset();
    t_single();
    t_hold();
    t_wrap();
    t_simul();
    t_mode();
    t_clear();
    t_reset_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule